// File: doc/BRIEF.md
# Dual-Clock Gray-Pointer FIFO

This block carries a stream of data words from one clock domain to another through a small storage array of 2^AW entries. The producer pushes a word by raising a write enable while the full flag is low. The consumer sees the oldest stored word on its data output whenever the empty flag is low, and removes it by raising a read enable.

Each side owns a pointer one bit wider than the storage address, held as a Gray code, so one bit changes per step. Only that registered Gray value crosses into the other domain, through a chain of flops. The storage address and the lap (wrap) bit are decoded from the Gray value itself. The lap bit is the pointer MSB. The address MSB is the XOR of the two top pointer bits, and the other address bits are the lower pointer bits. Each side compares its own next pointer against the synchronized copy of the other one to register its flag.

The flags are conservative. A side raises its own flag in the same clock edge as the operation that fills or drains the array. A flag clears only after the other side's pointer has passed through the synchronizer.

Top module: `gray_fifo`

## Requirements
- R1: While rst_ni is low, and after its release with no traffic, empty_o is 1 and full_o is 0.
- R2: Words leave on rd_data_o in the order they were accepted on wr_data_i, across many wraps of both pointers and under any ratio of write and read activity.
- R3: A write attempted while full_o is 1 is dropped: no stored word is overwritten and no extra word is later read out.
- R4: A read attempted while empty_o is 1 has no effect: the next word written is the next word presented on rd_data_o.
- R5: With no reads, full_o is 0 after 2^AW - 1 accepted writes and is 1 from the write clock edge that accepts write number 2^AW (8 with the default AW = 3).
- R6: full_o rises only on a write clock edge that accepts a write.
- R7: empty_o is 1 from the read clock edge that removes the last stored word, and rises only on a read clock edge that accepts a read.
- R8: After a write into an empty FIFO, empty_o stays 1 for at least the first read clock edge, and falls within SYNC_STAGES + 2 read clock edges.
- R9: After a read from a full FIFO, full_o stays 1 for at least the first write clock edge, and falls within a few write clock edges once the read pointer has been synchronized.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Write domain clock |
| rd_clk_i | input | 1 | Read domain clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| wr_en_i | input | 1 | Push request, write domain |
| wr_data_i | input | DW | Word to push |
| full_o | output | 1 | No free entry, write domain |
| rd_en_i | input | 1 | Pop request, read domain |
| rd_data_o | output | DW | Oldest stored word, valid while empty_o is 0 |
| empty_o | output | 1 | No stored word, read domain |

## Verification
On every cycle, the checker confirms three things. Each pointer changes by at most one bit. A blocked write or read leaves its pointer untouched. Each flag rises only on an edge where its own side accepted an operation. The bench alone can show the rest. It shows word ordering across pointer wraps, the exact capacity at which full appears, and the absence of an overwrite after a dropped write. It also shows the lag with which empty and full clear after a transfer on the other side.

// File: rtl/gfifo_pkg.sv
package gfifo_pkg;
  typedef enum logic {SIDE_WR = 1'b0, SIDE_RD = 1'b1} side_e;
endpackage

// File: rtl/gfifo_sync.sv
module gfifo_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else             stg_q[s] <= stg_q[(s > 0) ? s-1 : 0];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gfifo_mem.sv
module gfifo_mem #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/gfifo_ptr.sv
module gfifo_ptr
  import gfifo_pkg::*;
#(
  parameter int    AW   = 3,
  parameter side_e SIDE = SIDE_WR
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW:0]   peer_gray_i,
  output logic [AW:0]   gray_o,
  output logic [AW-1:0] addr_o,
  output logic          flag_o
);
  localparam logic FLAG_RST = (SIDE == SIDE_RD);

  logic [AW:0] bin_q, bin_d, gray_d;
  logic        flag_d;

  // lap bit is the MSB; address MSB folds the lap bit into the next Gray bit
  function automatic logic [AW-1:0] g2a(input logic [AW:0] g);
    logic [AW-1:0] a;
    a       = g[AW-1:0];
    a[AW-1] = g[AW] ^ g[AW-1];
    return a;
  endfunction

  assign bin_d  = bin_q + {{AW{1'b0}}, req_i & ~flag_o};
  assign gray_d = bin_d ^ (bin_d >> 1);

  if (SIDE == SIDE_WR) begin : g_full
    assign flag_d = (gray_d[AW] != peer_gray_i[AW]) && (g2a(gray_d) == g2a(peer_gray_i));
  end else begin : g_empty
    assign flag_d = (gray_d[AW] == peer_gray_i[AW]) && (g2a(gray_d) == g2a(peer_gray_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_o <= '0;
      flag_o <= FLAG_RST;
    end else begin
      bin_q  <= bin_d;
      gray_o <= gray_d;
      flag_o <= flag_d;
    end
  end

  assign addr_o = g2a(gray_o);
endmodule

// File: rtl/gray_fifo.sv
module gray_fifo
  import gfifo_pkg::*;
#(
  parameter int DW          = 8,
  parameter int AW          = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic          wr_clk_i,
  input  logic          rd_clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          full_o,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  output logic          empty_o
);
  logic [AW:0]   wr_gray, rd_gray, wr_gray_s, rd_gray_s;
  logic [AW-1:0] wr_addr, rd_addr;

  gfifo_ptr #(.AW(AW), .SIDE(SIDE_WR)) u_wptr (
    .clk_i(wr_clk_i), .rst_ni(rst_ni), .req_i(wr_en_i), .peer_gray_i(rd_gray_s),
    .gray_o(wr_gray), .addr_o(wr_addr), .flag_o(full_o)
  );

  gfifo_ptr #(.AW(AW), .SIDE(SIDE_RD)) u_rptr (
    .clk_i(rd_clk_i), .rst_ni(rst_ni), .req_i(rd_en_i), .peer_gray_i(wr_gray_s),
    .gray_o(rd_gray), .addr_o(rd_addr), .flag_o(empty_o)
  );

  gfifo_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_w2r (
    .clk_i(rd_clk_i), .rst_ni(rst_ni), .d_i(wr_gray), .q_o(wr_gray_s)
  );

  gfifo_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_r2w (
    .clk_i(wr_clk_i), .rst_ni(rst_ni), .d_i(rd_gray), .q_o(rd_gray_s)
  );

  gfifo_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk_i(wr_clk_i), .we_i(wr_en_i & ~full_o), .waddr_i(wr_addr), .wdata_i(wr_data_i),
    .raddr_i(rd_addr), .rdata_o(rd_data_o)
  );
endmodule

// File: rtl/gray_fifo_chk.sv
module gray_fifo_chk #(
  parameter int AW = 3
) (
  input logic        wr_clk_i,
  input logic        rd_clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic        rd_en_i,
  input logic        full_o,
  input logic        empty_o,
  input logic [AW:0] wr_gray,
  input logic [AW:0] rd_gray
);
  assert_no_overflow_R3: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    (wr_en_i && full_o) |=> $stable(wr_gray));

  assert_no_underflow_R4: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    (rd_en_i && empty_o) |=> $stable(rd_gray));

  assert_wr_gray_step_R2: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);

  assert_rd_gray_step_R2: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    $countones(rd_gray ^ $past(rd_gray)) <= 1);

  assert_full_rise_R6: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    (!full_o && !wr_en_i) |=> !full_o);

  assert_empty_rise_R7: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    (!empty_o && !rd_en_i) |=> !empty_o);
endmodule

bind gray_fifo gray_fifo_chk #(.AW(AW)) u_chk (
  .wr_clk_i(wr_clk_i), .rd_clk_i(rd_clk_i), .rst_ni(rst_ni),
  .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .full_o(full_o), .empty_o(empty_o),
  .wr_gray(wr_gray), .rd_gray(rd_gray)
);

// File: tb/gray_fifo_bench.sv
`timescale 1ns/1ps
module gray_fifo_bench;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;

  logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rd_data;
  logic full, empty;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [DW-1:0] mq[$];

  always #2 wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  gray_fifo #(.DW(DW), .AW(AW), .SYNC_STAGES(2)) u_gray_fifo (
    .wr_clk_i(wclk), .rd_clk_i(rclk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_data_i(wdata), .full_o(full),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .empty_o(empty)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] fill_val(input int i);
    return DW'(8'h10 + i);
  endfunction

  task automatic rand_writer(input int n, input int rate);
    int sent = 0;
    while (sent < n) begin
      @(negedge wclk);
      if (($urandom % 100) < rate) begin
        wr_en = 1'b1;
        wdata = DW'($urandom);
        if (!full) begin mq.push_back(wdata); sent++; end
      end else wr_en = 1'b0;
    end
    @(negedge wclk); wr_en = 1'b0;
  endtask

  task automatic rand_reader(input int n, input int rate);
    int got = 0;
    while (got < n) begin
      @(negedge rclk);
      rd_en = 1'b0;
      if (!empty && (($urandom % 100) < rate)) begin
        chk(mq.size() > 0 && rd_data == mq[0], "R2", rd_data, (mq.size() > 0) ? mq[0] : 0);
        if (mq.size() > 0) void'(mq.pop_front());
        rd_en = 1'b1;
        got++;
      end
    end
    @(negedge rclk); rd_en = 1'b0;
    chk(empty == 1'b1, "R7", empty, 1);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #10;
    chk(empty == 1'b1, "R1", empty, 1);
    chk(full == 1'b0, "R1", full, 0);
    #5 rst_n = 1'b1;
    repeat (4) @(negedge rclk);
    chk(empty == 1'b1 && full == 1'b0, "R1", {full, empty}, 2'b01);

    // reads on an empty FIFO
    for (int i = 0; i < 5; i++) begin
      @(negedge rclk); rd_en = 1'b1;
      chk(empty == 1'b1, "R4", empty, 1);
    end
    @(negedge rclk); rd_en = 1'b0;

    // single write, empty clears with lag
    @(negedge wclk); wr_en = 1'b1; wdata = 8'hA5;
    @(negedge wclk); wr_en = 1'b0;
    @(posedge rclk); #0.5;
    chk(empty == 1'b1, "R8", empty, 1);
    repeat (4) @(negedge rclk);
    chk(empty == 1'b0, "R8", empty, 0);
    chk(rd_data == 8'hA5, "R4", rd_data, 8'hA5);

    // pop the last word
    @(negedge rclk); rd_en = 1'b1;
    @(negedge rclk); rd_en = 1'b0;
    chk(empty == 1'b1, "R7", empty, 1);

    // fill to capacity
    repeat (10) @(negedge wclk);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge wclk);
      chk(full == 1'b0, "R5", full, 0);
      wr_en = 1'b1; wdata = fill_val(i);
    end
    @(negedge wclk); wr_en = 1'b0;
    chk(full == 1'b1, "R5", full, 1);

    // writes while full
    for (int i = 0; i < 3; i++) begin
      @(negedge wclk); wr_en = 1'b1; wdata = 8'hEE;
    end
    @(negedge wclk); wr_en = 1'b0;
    chk(full == 1'b1, "R3", full, 1);

    // one read, full clears with lag
    repeat (6) @(negedge rclk);
    chk(rd_data == fill_val(0), "R2", rd_data, fill_val(0));
    rd_en = 1'b1;
    @(negedge rclk); rd_en = 1'b0;
    @(negedge wclk);
    chk(full == 1'b1, "R9", full, 1);
    repeat (10) @(negedge wclk);
    chk(full == 1'b0, "R9", full, 0);

    // drain: originals intact, dropped word absent
    for (int i = 1; i < DEPTH; i++) begin
      @(negedge rclk);
      chk(!empty && rd_data == fill_val(i), "R3", rd_data, fill_val(i));
      rd_en = 1'b1;
    end
    @(negedge rclk); rd_en = 1'b0;
    chk(empty == 1'b1, "R3", empty, 1);

    // random traffic, writer-heavy then reader-heavy
    fork
      rand_writer(1000, 90);
      rand_reader(1000, 30);
    join
    fork
      rand_writer(1000, 30);
      rand_reader(1000, 90);
    join

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule